// File: doc/BRIEF.md
# USB Endpoint Transaction Control Bank

This block holds the per-endpoint control state of a USB device function for a bank of endpoints (eight by default). Each endpoint has four 32-bit words on a CPU register port: a buffer segment, a packet length, a configuration word and a control word. Firmware arms an endpoint by writing its length word. It can also stall the endpoint, or withdraw a pending arm before a transaction begins.

On the token side, the serial engine presents a decoded IN or OUT token with its endpoint number. One cycle later the bank returns one of four answers: a data response, NAK, STALL, or an isochronous data phase without a handshake. With the answer it gives the packet buffer start address, the byte length and the DATA0/DATA1 selector. When the engine reports a completed data phase, the bank updates the armed endpoint. It disarms the endpoint and then either toggles the sequence bit (IN) or stores the received byte count (OUT). An oversized OUT packet is flagged and leaves the endpoint armed.

Top module: `usb_ep_bank`

## Requirements
- R1: Endpoint i occupies four words at BANK_BASE + 16*i: +0 segment, +4 length, +8 configuration, +0xC control. All fields reset to zero. A read outside the bank window returns 0.
- R2: The segment field is write bits [8:3] and reads back at bits [8:3] with bits [2:0] as zero. The buffer start address of a response is SRAM_BASE + segment*8.
- R3: Writing the length word stores bits [8:0] as the 9-bit length and arms the endpoint. A read returns the stored length.
- R4: The configuration word has these fields: endpoint number [3:0], isochronous [4], mode [6:5] (00 off, 01 OUT, 10 IN, 11 undefined) and sequence bit [7]. Writing 1 to bit 9 clears the stall flag. Bit 9 always reads as 0.
- R5: Control bit 0 is write-one: it disarms the endpoint and always reads 0. Control bit 1 takes the written value as the stall flag and reads back.
- R6: A token hits an endpoint whose number equals the token number and whose mode is IN for an IN token or OUT for an OUT token. If several endpoints hit, the lowest index wins. A token that hits nothing gets no response (rsp_valid stays 0).
- R7: For a non-isochronous hit the answer is chosen in this order: STALL (code 2) if stalled, else NAK (code 1) if not armed, else DATA (code 0).
- R8: For an isochronous hit, the stall flag is ignored. If the endpoint is armed the answer is code 3. If it is not armed there is no response.
- R9: The response appears in the cycle after the token. It carries the buffer address, the stored length and the sequence bit as rsp_pid (0 = DATA0).
- R10: A successful completion of an IN data phase disarms the endpoint and toggles its sequence bit. The length is left unchanged.
- R11: A successful completion of an OUT data phase with a count no larger than the armed length disarms the endpoint and stores the count as its length. The sequence bit is left unchanged.
- R12: A successful OUT completion with a count above the armed length raises ovf_err for one cycle, in the cycle after xfer_done. The endpoint stays armed and keeps its length.
- R13: A completion with xfer_ok = 0, or one that follows no pending data or isochronous answer, changes no endpoint state. Any new token clears a pending transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | CPU_AW | Register byte address |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Register read data, combinational from cpu_addr |
| tok_valid | input | 1 | Decoded token present |
| tok_in | input | 1 | 1 = IN token, 0 = OUT token |
| tok_ep | input | 4 | Token endpoint number |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_code | output | 2 | 0 DATA, 1 NAK, 2 STALL, 3 isochronous data |
| rsp_pid | output | 1 | Data PID selector, 0 = DATA0, 1 = DATA1 |
| rsp_addr | output | BUF_AW | Packet buffer start address |
| rsp_len | output | 9 | Stored length of the chosen endpoint |
| xfer_done | input | 1 | Data phase finished |
| xfer_ok | input | 1 | Data phase finished without error |
| xfer_cnt | input | 9 | Bytes moved in the data phase |
| ovf_err | output | 1 | OUT packet longer than the armed length |

## Verification
The hardest states to reach are a priority collision between two endpoints and the oversize OUT case. For the collision, two endpoints carry the same number and direction. The bench shows that the lower index answers even while it is not armed, then disables it and sees the higher index take over. For the oversize case, the bench sends a completion larger than the armed length, then checks that the next token is still served with data. It then sends a failed completion and a completion with nothing pending, and observes through reads and responses that neither touched the endpoint.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;

   localparam int REG_W        = 32;
   localparam int LEN_W        = 9;
   localparam int SEG_W        = 6;
   localparam int SEG_LSB      = 3;
   localparam int EPN_W        = 4;

   localparam int CFG_NUM_LSB  = 0;
   localparam int CFG_ISO      = 4;
   localparam int CFG_MODE_LSB = 5;
   localparam int CFG_SEQ      = 7;
   localparam int CFG_UNSTALL  = 9;
   localparam int CTL_DISARM   = 0;
   localparam int CTL_STALL    = 1;

   typedef enum logic [1:0] {
      RSP_DATA  = 2'd0,
      RSP_NAK   = 2'd1,
      RSP_STALL = 2'd2,
      RSP_ISO   = 2'd3
   } rsp_code_e;

   typedef enum logic [1:0] {
      EPM_OFF   = 2'd0,
      EPM_OUT   = 2'd1,
      EPM_IN    = 2'd2,
      EPM_UNDEF = 2'd3
   } ep_mode_e;

   typedef enum logic [1:0] {
      WD_SEG = 2'd0,
      WD_LEN = 2'd1,
      WD_CFG = 2'd2,
      WD_CTL = 2'd3
   } reg_word_e;

endpackage

// File: rtl/usb_ep_slot.sv
module usb_ep_slot
   import usb_ep_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  reg_word_e            wr_word,
   input  logic [REG_W-1:0]     wdata,
   input  reg_word_e            rd_word,
   output logic [REG_W-1:0]     rdata,
   input  logic                 upd,
   input  logic                 upd_in,
   input  logic [LEN_W-1:0]     upd_cnt,
   output logic [EPN_W-1:0]     ep_num,
   output logic                 ep_iso,
   output ep_mode_e             ep_mode,
   output logic                 ep_seq,
   output logic                 ep_ready,
   output logic                 ep_stall,
   output logic [SEG_W-1:0]     ep_seg,
   output logic [LEN_W-1:0]     ep_len
);

   logic unused_wd;
   assign unused_wd = ^wdata[REG_W-1:CFG_UNSTALL+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ep_num   <= '0;
         ep_iso   <= 1'b0;
         ep_mode  <= EPM_OFF;
         ep_seq   <= 1'b0;
         ep_ready <= 1'b0;
         ep_stall <= 1'b0;
         ep_seg   <= '0;
         ep_len   <= '0;
      end else begin
         if (upd) begin
            ep_ready <= 1'b0;
            if (upd_in) ep_seq <= ~ep_seq;
            else        ep_len <= upd_cnt;
         end
         if (wr_en) begin
            unique case (wr_word)
               WD_SEG: ep_seg <= wdata[SEG_LSB +: SEG_W];
               WD_LEN: begin
                  ep_len   <= wdata[LEN_W-1:0];
                  ep_ready <= 1'b1;
               end
               WD_CFG: begin
                  ep_num  <= wdata[CFG_NUM_LSB +: EPN_W];
                  ep_iso  <= wdata[CFG_ISO];
                  ep_mode <= ep_mode_e'(wdata[CFG_MODE_LSB +: 2]);
                  ep_seq  <= wdata[CFG_SEQ];
                  if (wdata[CFG_UNSTALL]) ep_stall <= 1'b0;
               end
               WD_CTL: begin
                  if (wdata[CTL_DISARM]) ep_ready <= 1'b0;
                  ep_stall <= wdata[CTL_STALL];
               end
            endcase
         end
      end
   end

   always_comb begin
      rdata = '0;
      unique case (rd_word)
         WD_SEG: rdata[SEG_LSB +: SEG_W] = ep_seg;
         WD_LEN: rdata[LEN_W-1:0]        = ep_len;
         WD_CFG: begin
            rdata[CFG_NUM_LSB +: EPN_W] = ep_num;
            rdata[CFG_ISO]              = ep_iso;
            rdata[CFG_MODE_LSB +: 2]    = ep_mode;
            rdata[CFG_SEQ]              = ep_seq;
         end
         WD_CTL: rdata[CTL_STALL] = ep_stall;
      endcase
   end

   AST_LEN_WRITE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_word == WD_LEN) |=> (ep_ready && ep_len == $past(wdata[LEN_W-1:0]))); // R3

   AST_CLEAR_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_word == WD_CTL && wdata[CTL_DISARM]) |=> !ep_ready); // R5

   AST_IN_DONE_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && upd_in && !wr_en) |=> (ep_seq != $past(ep_seq))); // R10

   AST_DONE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !(wr_en && wr_word == WD_LEN)) |=> !ep_ready); // R11

endmodule

// File: rtl/usb_ep_match.sv
module usb_ep_match
   import usb_ep_pkg::*;
#(
   parameter int NUM_EP = 8,
   parameter int IDX_W  = 3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tok_in,
   input  logic [EPN_W-1:0]  tok_ep,
   input  logic [EPN_W-1:0]  ep_num  [NUM_EP],
   input  ep_mode_e          ep_mode [NUM_EP],
   output logic              hit,
   output logic [IDX_W-1:0]  hit_idx
);

   logic [NUM_EP-1:0] want;
   ep_mode_e          tok_mode;

   assign tok_mode = tok_in ? EPM_IN : EPM_OUT;

   for (genvar g = 0; g < NUM_EP; g++) begin : g_cmp
      assign want[g] = (ep_num[g] == tok_ep) && (ep_mode[g] == tok_mode);
   end

   always_comb begin
      hit     = 1'b0;
      hit_idx = '0;
      for (int i = NUM_EP - 1; i >= 0; i--) begin
         if (want[i]) begin
            hit     = 1'b1;
            hit_idx = IDX_W'(i);
         end
      end
   end

   logic [NUM_EP-1:0] below_mask;
   assign below_mask = (NUM_EP'(1) << hit_idx) - NUM_EP'(1);

   AST_MATCH_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (want[hit_idx] && ((want & below_mask) == '0))); // R6

   AST_MATCH_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
      (want != '0) |-> hit); // R6

endmodule

// File: rtl/usb_ep_xact.sv
module usb_ep_xact
   import usb_ep_pkg::*;
#(
   parameter int NUM_EP    = 8,
   parameter int IDX_W     = 3,
   parameter int BUF_AW    = 12,
   parameter int SRAM_BASE = 'h100
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tok_valid,
   input  logic              tok_in,
   input  logic              hit,
   input  logic [IDX_W-1:0]  hit_idx,
   input  logic              sel_iso,
   input  logic              sel_stall,
   input  logic              sel_ready,
   input  logic              sel_seq,
   input  logic [SEG_W-1:0]  sel_seg,
   input  logic [LEN_W-1:0]  sel_len,
   input  logic              xfer_done,
   input  logic              xfer_ok,
   input  logic [LEN_W-1:0]  xfer_cnt,
   output logic              rsp_valid,
   output rsp_code_e         rsp_code,
   output logic              rsp_pid,
   output logic [BUF_AW-1:0] rsp_addr,
   output logic [LEN_W-1:0]  rsp_len,
   output logic [NUM_EP-1:0] upd_vec,
   output logic              upd_in,
   output logic [LEN_W-1:0]  upd_cnt,
   output logic              ovf_err
);

   localparam logic [BUF_AW-1:0] BASE_V = BUF_AW'(SRAM_BASE);

   rsp_code_e         pick_code;
   logic              pick_go;
   logic              pick_data;
   logic [BUF_AW-1:0] pick_addr;

   logic              act_vld;
   logic [IDX_W-1:0]  act_idx;
   logic              act_in;
   logic [LEN_W-1:0]  act_len;
   logic              cmp_hit;
   logic              cmp_ovf;
   logic              cmp_commit;

   always_comb begin
      pick_code = RSP_DATA;
      pick_go   = 1'b0;
      if (sel_iso) begin
         pick_code = RSP_ISO;
         pick_go   = sel_ready;
      end else if (sel_stall) begin
         pick_code = RSP_STALL;
         pick_go   = 1'b1;
      end else if (!sel_ready) begin
         pick_code = RSP_NAK;
         pick_go   = 1'b1;
      end else begin
         pick_code = RSP_DATA;
         pick_go   = 1'b1;
      end
      pick_go   = pick_go && hit;
      pick_data = pick_go && (pick_code == RSP_DATA || pick_code == RSP_ISO);
   end

   assign pick_addr = BASE_V + BUF_AW'({sel_seg, 3'b000});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_code  <= RSP_DATA;
         rsp_pid   <= 1'b0;
         rsp_addr  <= '0;
         rsp_len   <= '0;
      end else begin
         rsp_valid <= tok_valid && pick_go;
         if (tok_valid) begin
            rsp_code <= pick_code;
            rsp_pid  <= sel_seq;
            rsp_addr <= pick_addr;
            rsp_len  <= sel_len;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_vld <= 1'b0;
         act_idx <= '0;
         act_in  <= 1'b0;
         act_len <= '0;
      end else if (tok_valid) begin
         act_vld <= pick_data;
         act_idx <= hit_idx;
         act_in  <= tok_in;
         act_len <= sel_len;
      end else if (xfer_done) begin
         act_vld <= 1'b0;
      end
   end

   assign cmp_hit    = act_vld && xfer_done && xfer_ok;
   assign cmp_ovf    = cmp_hit && !act_in && (xfer_cnt > act_len);
   assign cmp_commit = cmp_hit && !cmp_ovf;
   assign upd_in     = act_in;
   assign upd_cnt    = xfer_cnt;

   for (genvar g = 0; g < NUM_EP; g++) begin : g_upd
      assign upd_vec[g] = cmp_commit && (act_idx == IDX_W'(g));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovf_err <= 1'b0;
      else        ovf_err <= cmp_ovf;
   end

   AST_NO_HIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_valid && !hit) |=> !rsp_valid); // R6

   AST_STALL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_valid && hit && !sel_iso && sel_stall) |=> (rsp_valid && rsp_code == RSP_STALL)); // R7

   AST_NAK_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_valid && hit && !sel_iso && !sel_stall && !sel_ready) |=> (rsp_valid && rsp_code == RSP_NAK)); // R7

   AST_ISO_NO_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_code != RSP_ISO) |-> !$past(sel_iso)); // R8

   AST_RSP_AFTER_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(tok_valid)); // R9

   AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_addr[2:0] == BASE_V[2:0])); // R2

   AST_OVF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_err |-> $past(xfer_done && xfer_ok && !act_in)); // R12

   AST_ONE_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(upd_vec)); // R13

endmodule

// File: rtl/usb_ep_bank.sv
module usb_ep_bank
   import usb_ep_pkg::*;
#(
   parameter int NUM_EP    = 8,
   parameter int CPU_AW    = 12,
   parameter int BUF_AW    = 12,
   parameter int BANK_BASE = 'h500,
   parameter int SRAM_BASE = 'h100
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr,
   input  logic [CPU_AW-1:0] cpu_addr,
   input  logic [31:0]       cpu_wdata,
   output logic [31:0]       cpu_rdata,
   input  logic              tok_valid,
   input  logic              tok_in,
   input  logic [3:0]        tok_ep,
   output logic              rsp_valid,
   output logic [1:0]        rsp_code,
   output logic              rsp_pid,
   output logic [BUF_AW-1:0] rsp_addr,
   output logic [8:0]        rsp_len,
   input  logic              xfer_done,
   input  logic              xfer_ok,
   input  logic [8:0]        xfer_cnt,
   output logic              ovf_err
);

   localparam int IDX_W    = (NUM_EP > 1) ? $clog2(NUM_EP) : 1;
   localparam int STRIDE   = 16;
   localparam int WIN_SPAN = NUM_EP * STRIDE;
   localparam logic [CPU_AW:0]   WIN_LO = (CPU_AW+1)'(BANK_BASE);
   localparam logic [CPU_AW:0]   WIN_HI = (CPU_AW+1)'(BANK_BASE + WIN_SPAN);
   localparam logic [CPU_AW-1:0] WIN_BASE = CPU_AW'(BANK_BASE);

   if (NUM_EP < 1 || NUM_EP > 16 || (NUM_EP & (NUM_EP - 1)) != 0) begin : g_chk_ep
      $error("usb_ep_bank: NUM_EP must be a power of two between 1 and 16");
   end
   if ((BANK_BASE % STRIDE) != 0) begin : g_chk_base
      $error("usb_ep_bank: BANK_BASE must be 16-byte aligned");
   end
   if (CPU_AW <= 4 + IDX_W || BANK_BASE + WIN_SPAN > (1 << CPU_AW)) begin : g_chk_aw
      $error("usb_ep_bank: CPU_AW too narrow for the register window");
   end
   if (BUF_AW < SEG_W + SEG_LSB) begin : g_chk_buf
      $error("usb_ep_bank: BUF_AW too narrow for the buffer offset");
   end

   logic              in_win;
   logic [CPU_AW-1:0] win_off;
   logic [IDX_W-1:0]  slot_idx;
   reg_word_e         slot_word;
   logic              unused_off;

   assign in_win    = ({1'b0, cpu_addr} >= WIN_LO) && ({1'b0, cpu_addr} < WIN_HI);
   assign win_off   = cpu_addr - WIN_BASE;
   assign slot_idx  = win_off[4 +: IDX_W];
   assign slot_word = reg_word_e'(win_off[3:2]);
   assign unused_off = ^{win_off[1:0], win_off[CPU_AW-1:4+IDX_W]};

   logic [REG_W-1:0] a_rdata [NUM_EP];
   logic [EPN_W-1:0] a_num   [NUM_EP];
   ep_mode_e         a_mode  [NUM_EP];
   logic             a_iso   [NUM_EP];
   logic             a_seq   [NUM_EP];
   logic             a_ready [NUM_EP];
   logic             a_stall [NUM_EP];
   logic [SEG_W-1:0] a_seg   [NUM_EP];
   logic [LEN_W-1:0] a_len   [NUM_EP];

   logic [NUM_EP-1:0] upd_vec;
   logic              upd_in;
   logic [LEN_W-1:0]  upd_cnt;

   for (genvar g = 0; g < NUM_EP; g++) begin : g_slot
      logic slot_wr;
      assign slot_wr = cpu_wr && in_win && (slot_idx == IDX_W'(g));

      usb_ep_slot u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (slot_wr),
         .wr_word  (slot_word),
         .wdata    (cpu_wdata),
         .rd_word  (slot_word),
         .rdata    (a_rdata[g]),
         .upd      (upd_vec[g]),
         .upd_in   (upd_in),
         .upd_cnt  (upd_cnt),
         .ep_num   (a_num[g]),
         .ep_iso   (a_iso[g]),
         .ep_mode  (a_mode[g]),
         .ep_seq   (a_seq[g]),
         .ep_ready (a_ready[g]),
         .ep_stall (a_stall[g]),
         .ep_seg   (a_seg[g]),
         .ep_len   (a_len[g])
      );
   end

   assign cpu_rdata = in_win ? a_rdata[slot_idx] : '0;

   logic             hit;
   logic [IDX_W-1:0] hit_idx;

   usb_ep_match #(
      .NUM_EP (NUM_EP),
      .IDX_W  (IDX_W)
   ) u_match (
      .clk     (clk),
      .rst_n   (rst_n),
      .tok_in  (tok_in),
      .tok_ep  (tok_ep),
      .ep_num  (a_num),
      .ep_mode (a_mode),
      .hit     (hit),
      .hit_idx (hit_idx)
   );

   rsp_code_e code_q;

   usb_ep_xact #(
      .NUM_EP    (NUM_EP),
      .IDX_W     (IDX_W),
      .BUF_AW    (BUF_AW),
      .SRAM_BASE (SRAM_BASE)
   ) u_xact (
      .clk       (clk),
      .rst_n     (rst_n),
      .tok_valid (tok_valid),
      .tok_in    (tok_in),
      .hit       (hit),
      .hit_idx   (hit_idx),
      .sel_iso   (a_iso[hit_idx]),
      .sel_stall (a_stall[hit_idx]),
      .sel_ready (a_ready[hit_idx]),
      .sel_seq   (a_seq[hit_idx]),
      .sel_seg   (a_seg[hit_idx]),
      .sel_len   (a_len[hit_idx]),
      .xfer_done (xfer_done),
      .xfer_ok   (xfer_ok),
      .xfer_cnt  (xfer_cnt),
      .rsp_valid (rsp_valid),
      .rsp_code  (code_q),
      .rsp_pid   (rsp_pid),
      .rsp_addr  (rsp_addr),
      .rsp_len   (rsp_len),
      .upd_vec   (upd_vec),
      .upd_in    (upd_in),
      .upd_cnt   (upd_cnt),
      .ovf_err   (ovf_err)
   );

   assign rsp_code = code_q;

   AST_OUTSIDE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !in_win |-> (cpu_rdata == '0)); // R1

endmodule

// File: tb/sim_usb_ep_bank.sv
`timescale 1ns/1ps
module sim_usb_ep_bank;

   localparam int C_DATA = 0, C_NAK = 1, C_STALL = 2, C_ISO = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_wr = 1'b0;
   logic [11:0] cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic [31:0] cpu_rdata;
   logic        tok_valid = 1'b0;
   logic        tok_in = 1'b0;
   logic [3:0]  tok_ep = '0;
   logic        rsp_valid;
   logic [1:0]  rsp_code;
   logic        rsp_pid;
   logic [11:0] rsp_addr;
   logic [8:0]  rsp_len;
   logic        xfer_done = 1'b0;
   logic        xfer_ok = 1'b0;
   logic [8:0]  xfer_cnt = '0;
   logic        ovf_err;

   always #4 clk = ~clk;

   usb_ep_bank u0 (
      .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .tok_valid(tok_valid),
      .tok_in(tok_in), .tok_ep(tok_ep), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
      .rsp_pid(rsp_pid), .rsp_addr(rsp_addr), .rsp_len(rsp_len),
      .xfer_done(xfer_done), .xfer_ok(xfer_ok), .xfer_cnt(xfer_cnt), .ovf_err(ovf_err)
   );

   typedef struct {
      logic [23:0] v;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   finished = 0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops scoreboard on every response
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R6 unexpected response actual=%h expected=none",
                     {rsp_code, rsp_pid, rsp_addr, rsp_len});
         end else begin
            exp_t e;
            e = q.pop_front();
            chk(e.tag, {8'h0, rsp_code, rsp_pid, rsp_addr, rsp_len}, {8'h0, e.v});
         end
      end
   end

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk); cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
      @(negedge clk); cpu_wr = 1'b0;
   endtask

   task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
      @(negedge clk); cpu_addr = a; #1;
      chk(tag, cpu_rdata, exp);
   endtask

   task automatic tok(bit in, logic [3:0] ep, bit expect_rsp, int code, bit pid,
                      logic [11:0] addr, logic [8:0] len, string tag);
      @(negedge clk); tok_valid = 1'b1; tok_in = in; tok_ep = ep;
      if (expect_rsp) begin
         exp_t e;
         e.v = {code[1:0], pid, addr, len};
         e.tag = tag;
         q.push_back(e);
      end
      @(negedge clk); tok_valid = 1'b0;
      if (!expect_rsp) chk(tag, {31'h0, rsp_valid}, 32'h0);
   endtask

   task automatic done(bit ok, logic [8:0] cnt, bit exp_ovf, string tag);
      @(negedge clk); xfer_done = 1'b1; xfer_ok = ok; xfer_cnt = cnt;
      @(negedge clk); xfer_done = 1'b0; xfer_ok = 1'b0;
      chk(tag, {31'h0, ovf_err}, {31'h0, exp_ovf});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state and window edges
      rd(12'h500, 0, "R1 ep0 seg reset");
      rd(12'h504, 0, "R1 ep0 len reset");
      rd(12'h508, 0, "R1 ep0 cfg reset");
      rd(12'h57C, 0, "R1 ep7 ctl reset");
      rd(12'h400, 0, "R1 below window");

      // ep0: IN endpoint number 1, buffer segment 2
      wr(12'h500, 32'h10);
      wr(12'h508, 32'h41);
      rd(12'h508, 32'h41, "R4 cfg readback");
      rd(12'h500, 32'h10, "R2 seg readback");
      tok(1, 1, 1, C_NAK, 0, 12'h110, 9'd0, "R7 NAK unarmed");
      wr(12'h504, 32'd64);
      rd(12'h504, 32'd64, "R3 len readback");
      tok(1, 1, 1, C_DATA, 0, 12'h110, 9'd64, "R9 IN data response");
      done(1, 9'd64, 0, "R10 IN done no ovf");
      rd(12'h508, 32'hC1, "R10 seq toggled");
      rd(12'h504, 32'd64, "R10 len kept");
      tok(1, 1, 1, C_NAK, 1, 12'h110, 9'd64, "R10 disarmed after IN");

      // ep1: OUT endpoint number 2, segment 5
      wr(12'h510, 32'h28);
      wr(12'h518, 32'h22);
      wr(12'h514, 32'd32);
      tok(0, 2, 1, C_DATA, 0, 12'h128, 9'd32, "R9 OUT data response");
      done(1, 9'd10, 0, "R11 OUT done no ovf");
      rd(12'h514, 32'd10, "R11 received count stored");
      rd(12'h518, 32'h22, "R11 seq unchanged");
      tok(0, 2, 1, C_NAK, 0, 12'h128, 9'd10, "R11 disarmed after OUT");

      // oversize OUT packet
      wr(12'h514, 32'd8);
      tok(0, 2, 1, C_DATA, 0, 12'h128, 9'd8, "R9 OUT re-armed");
      done(1, 9'd20, 1, "R12 ovf flagged");
      @(negedge clk);
      chk("R12 ovf one cycle", {31'h0, ovf_err}, 32'h0);
      rd(12'h514, 32'd8, "R12 len kept");
      tok(0, 2, 1, C_DATA, 0, 12'h128, 9'd8, "R12 still armed");
      done(0, 9'd3, 0, "R13 failed done");
      tok(0, 2, 1, C_DATA, 0, 12'h128, 9'd8, "R13 still armed after failed done");
      done(1, 9'd8, 0, "R11 exact length ok");
      rd(12'h514, 32'd8, "R11 exact length stored");
      tok(0, 2, 1, C_NAK, 0, 12'h128, 9'd8, "R11 disarmed");
      done(1, 9'd3, 0, "R13 done nothing pending");
      rd(12'h514, 32'd8, "R13 len untouched");

      // stall handling on ep0
      wr(12'h50C, 32'h2);
      rd(12'h50C, 32'h2, "R5 stall readback");
      wr(12'h504, 32'd16);
      tok(1, 1, 1, C_STALL, 1, 12'h110, 9'd16, "R7 STALL over armed");
      wr(12'h508, 32'h2C1);
      rd(12'h50C, 32'h0, "R4 unstall via cfg");
      rd(12'h508, 32'hC1, "R4 bit9 reads zero");
      tok(1, 1, 1, C_DATA, 1, 12'h110, 9'd16, "R7 DATA after unstall");
      wr(12'h50C, 32'h1);
      rd(12'h50C, 32'h0, "R5 disarm bit reads zero");
      tok(1, 1, 1, C_NAK, 1, 12'h110, 9'd16, "R5 disarmed by control");

      // priority between two endpoints with the same number
      wr(12'h520, 32'h38);
      wr(12'h528, 32'h41);
      wr(12'h524, 32'd5);
      tok(1, 1, 1, C_NAK, 1, 12'h110, 9'd16, "R6 lowest index wins");
      wr(12'h508, 32'h81);
      tok(1, 1, 1, C_DATA, 0, 12'h138, 9'd5, "R6 next index after disable");

      // silent cases
      tok(1, 9, 0, 0, 0, 0, 0, "R6 no endpoint number");
      tok(0, 1, 0, 0, 0, 0, 0, "R6 direction mismatch");
      wr(12'h538, 32'h64);
      tok(1, 4, 0, 0, 0, 0, 0, "R6 undefined mode IN");
      tok(0, 4, 0, 0, 0, 0, 0, "R6 undefined mode OUT");

      // isochronous OUT endpoint 5 on ep4
      wr(12'h548, 32'h35);
      tok(0, 5, 0, 0, 0, 0, 0, "R8 iso unarmed silent");
      wr(12'h54C, 32'h2);
      wr(12'h544, 32'd12);
      tok(0, 5, 1, C_ISO, 0, 12'h100, 9'd12, "R8 iso ignores stall");

      // last slot and segment masking
      wr(12'h570, 32'h1FF);
      rd(12'h570, 32'h1F8, "R2 seg low bits dropped");
      wr(12'h578, 32'h4F);
      wr(12'h574, 32'd9);
      tok(1, 15, 1, C_DATA, 0, 12'h2F8, 9'd9, "R2 top segment address");
      rd(12'h580, 0, "R1 above window");

      repeat (3) @(negedge clk);
      chk("R9 scoreboard drained", q.size(), 0);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule